// File: doc/BRIEF.md
# Configuration Bitstream Loader Front End

This block is the receiving end of a programmable device's configuration path. A configuration bitstream comes in over one of three interfaces. In the first, the block generates its own configuration clock and shifts in one bit per clock. In the second, an external clock delivers one bit per cycle. In the third, an external clock delivers one byte per cycle. The block packs the incoming data into 32-bit words and writes each word to a configuration memory port at ascending addresses. It stops writing once it has stored a programmed number of words.

After reset the controller stays in `INIT` for `INIT_CYCLES` system clocks. At the end of that window it latches the 3-bit mode pins and the word total once. It then moves to `LOAD`, to `PASS` (when the total is zero) or to `FAULT` (when the mode encoding is not recognised). `LOAD` moves to `PASS` when the last word is written. `PASS` and `FAULT` hold until reset. In `PASS` a serial-mode device forwards every further input bit on its daisy-chain output, so a device further down the chain can take the rest of the stream. Before `PASS` that output is held high.

All logic runs on one system clock. An external configuration clock is synchronised and its rising edge is detected. The generated clock is the system clock divided by `2*CCLK_HALF`.

Top module: `cfg_stream_loader`

## Requirements
- R1: The latched mode pins decode as follows: 3'b000 selects master serial, 3'b111 selects slave serial and 3'b110 selects byte-wide slave parallel. Every other value puts the block in `FAULT`: `mode_err`=1, no memory write, `cclk_oe`=0.
- R2: In master serial mode, after `INIT`, `cclk_oe`=1 and `cclk_out` toggles with a period of 2*`CCLK_HALF` system clocks. In any other mode, `cclk_oe`=0 and `cclk_out`=0.
- R3: In both serial modes exactly one bit of `ser_din` is taken per configuration clock rising edge, most significant bit first. Every 32 bits form one word.
- R4: In parallel mode one byte of `par_din` is taken per rising edge of `ext_cclk`. The first byte of a word lands in bits 31:24 and the fourth in bits 7:0.
- R5: Each word is written with a one-cycle `mem_we` pulse. Addresses start at 0 and rise by one per word.
- R6: Once `frame_total` words are written, `load_full`=1, it stays set, and no further write occurs. A total of 0 gives `load_full`=1 straight after `INIT` with no writes. A partial word never produces a write.
- R7: `dout` is 1 while `load_full`=0. In serial modes with `load_full`=1, `dout` takes each newly received bit at that bit's clock edge. In parallel mode `dout` stays 1.
- R8: The mode pins and `frame_total` are sampled once, on the last cycle of `INIT`. Values before that point and changes after it have no effect.
- R9: During and straight after reset: `mem_we`=0, `dout`=1, `mode_err`=0, `cclk_oe`=0, `load_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a new load |
| mode_pins | input | 3 | Interface select, latched at the end of `INIT` |
| frame_total | input | WCNT_W | Number of words to store locally, latched at the end of `INIT` |
| ext_cclk | input | 1 | External configuration clock (slave modes) |
| ser_din | input | 1 | Serial configuration data |
| par_din | input | 8 | Byte-wide configuration data |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| cclk_oe | output | 1 | Output enable for the generated clock |
| mem_we | output | 1 | Configuration memory write strobe |
| mem_addr | output | WCNT_W | Word address of the current write |
| mem_wdata | output | WORD_W | Assembled word |
| dout | output | 1 | Daisy-chain serial output |
| load_full | output | 1 | Local word total reached |
| mode_err | output | 1 | Unrecognised mode latched |

## Verification
The bench targets these corner cases:
- The word boundary in each mode. A bit-order or byte-lane error would show up as byte-reversed or bit-reversed words.
- The handover to pass-through. A late switch would write an extra word or leave `dout` high for the first forwarded bit. An early switch would drop the last word.
- A zero total, a trailing partial word, and mode pins that change both during `INIT` and in the middle of a load. A block that sampled the pins at the wrong moment would fault or change its width while loading.
- An unrecognised mode, which must write nothing and must not drive the clock.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [1:0] {
        M_MASTER_SER,
        M_SLAVE_SER,
        M_SLAVE_PAR,
        M_BAD
    } load_mode_t;

    typedef enum logic [1:0] {
        S_INIT,
        S_LOAD,
        S_PASS,
        S_FAULT
    } ld_state_t;

    localparam logic [2:0] PINS_MASTER_SER = 3'b000;
    localparam logic [2:0] PINS_SLAVE_SER  = 3'b111;
    localparam logic [2:0] PINS_SLAVE_PAR  = 3'b110;

    function automatic load_mode_t decode_pins(input logic [2:0] pins);
        load_mode_t m;
        unique case (pins)
            PINS_MASTER_SER: m = M_MASTER_SER;
            PINS_SLAVE_SER:  m = M_SLAVE_SER;
            PINS_SLAVE_PAR:  m = M_SLAVE_PAR;
            default:         m = M_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
#(
    parameter int INIT_CYCLES = 8,
    parameter int WCNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_pins,
    input  logic [WCNT_W-1:0] frame_total,
    input  logic              word_valid,
    output logic              load_en,
    output logic              pass_en,
    output logic              fault,
    output logic              master_run,
    output logic              slave_run,
    output logic              byte_mode,
    output logic [WCNT_W-1:0] word_idx
);

    localparam int ICW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

    ld_state_t         state, state_nx;
    load_mode_t        mode_q, mode_dec;
    logic [ICW-1:0]    init_cnt;
    logic [WCNT_W-1:0] total_q;
    logic              init_end;
    logic              last_word;

    assign mode_dec  = decode_pins(mode_pins);
    assign init_end  = (init_cnt == ICW'(INIT_CYCLES - 1));
    assign last_word = word_valid &&
                       (({1'b0, word_idx} + 1'b1) == {1'b0, total_q});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_INIT;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_INIT: begin
                if (init_end) begin
                    if (mode_dec == M_BAD)      state_nx = S_FAULT;
                    else if (frame_total == '0) state_nx = S_PASS;
                    else                        state_nx = S_LOAD;
                end
            end
            S_LOAD:  if (last_word) state_nx = S_PASS;
            S_PASS:  state_nx = S_PASS;
            S_FAULT: state_nx = S_FAULT;
            default: state_nx = S_INIT;
        endcase
    end

    // latched configuration and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt <= '0;
            mode_q   <= M_BAD;
            total_q  <= '0;
            word_idx <= '0;
        end else begin
            if (state == S_INIT) begin
                if (!init_end) begin
                    init_cnt <= init_cnt + 1'b1;
                end else begin
                    mode_q  <= mode_dec;
                    total_q <= frame_total;
                end
            end
            if (state == S_LOAD && word_valid) word_idx <= word_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_en    = (state == S_LOAD);
        pass_en    = (state == S_PASS);
        fault      = (state == S_FAULT);
        master_run = (load_en || pass_en) && (mode_q == M_MASTER_SER);
        slave_run  = (load_en || pass_en) &&
                     ((mode_q == M_SLAVE_SER) || (mode_q == M_SLAVE_PAR));
        byte_mode  = (mode_q == M_SLAVE_PAR);
    end

endmodule

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
    parameter int CCLK_HALF   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_run,
    input  logic slave_run,
    input  logic ext_cclk,
    output logic cclk_out,
    output logic beat
);

    localparam int HCW = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;

    logic                   cclk_q;
    logic                   half_tick;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_prev;
    logic                   beat_m, beat_s;

    generate
        if (CCLK_HALF == 1) begin : g_fast
            assign half_tick = 1'b1;
        end else begin : g_div
            logic [HCW-1:0] half_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              half_cnt <= '0;
                else if (!master_run)                    half_cnt <= '0;
                else if (half_cnt == HCW'(CCLK_HALF - 1)) half_cnt <= '0;
                else                                     half_cnt <= half_cnt + 1'b1;
            end
            assign half_tick = (half_cnt == HCW'(CCLK_HALF - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cclk_q <= 1'b0;
        else if (!master_run) cclk_q <= 1'b0;
        else if (half_tick)   cclk_q <= ~cclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '0;
            sync_prev <= 1'b0;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], ext_cclk};
            sync_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign beat_m   = master_run && half_tick && !cclk_q;
    assign beat_s   = slave_run && sync_q[SYNC_STAGES-1] && !sync_prev;
    assign beat     = beat_m || beat_s;
    assign cclk_out = cclk_q;

endmodule

// File: rtl/cfgl_assembler.sv
module cfgl_assembler #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              beat,
    input  logic              byte_mode,
    input  logic              ser_bit,
    input  logic [BYTE_W-1:0] par_byte,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam int SER_BEATS = WORD_W;
    localparam int PAR_BEATS = WORD_W / BYTE_W;
    localparam int BCW       = $clog2(SER_BEATS);

    logic [WORD_W-1:0] shreg, shreg_nx;
    logic [BCW-1:0]    beat_cnt;
    logic              last_beat;

    always_comb begin
        if (byte_mode) shreg_nx = {shreg[WORD_W-BYTE_W-1:0], par_byte};
        else           shreg_nx = {shreg[WORD_W-2:0], ser_bit};
        last_beat = byte_mode ? (beat_cnt == BCW'(PAR_BEATS - 1))
                              : (beat_cnt == BCW'(SER_BEATS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            beat_cnt   <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (!enable) begin
                beat_cnt <= '0;
            end else if (beat) begin
                shreg <= shreg_nx;
                if (last_beat) begin
                    beat_cnt   <= '0;
                    word_valid <= 1'b1;
                    word_data  <= shreg_nx;
                end else begin
                    beat_cnt <= beat_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
    parameter int INIT_CYCLES = 8,
    parameter int CCLK_HALF   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WCNT_W      = 8,
    parameter int WORD_W      = 32,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_pins,
    input  logic [WCNT_W-1:0] frame_total,
    input  logic              ext_cclk,
    input  logic              ser_din,
    input  logic [BYTE_W-1:0] par_din,
    output logic              cclk_out,
    output logic              cclk_oe,
    output logic              mem_we,
    output logic [WCNT_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              dout,
    output logic              load_full,
    output logic              mode_err
);

    logic load_en, pass_en, fault;
    logic master_run, slave_run, byte_mode;
    logic beat, word_valid;
    logic dout_q;

    cfgl_ctrl #(
        .INIT_CYCLES (INIT_CYCLES),
        .WCNT_W      (WCNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pins   (mode_pins),
        .frame_total (frame_total),
        .word_valid  (word_valid),
        .load_en     (load_en),
        .pass_en     (pass_en),
        .fault       (fault),
        .master_run  (master_run),
        .slave_run   (slave_run),
        .byte_mode   (byte_mode),
        .word_idx    (mem_addr)
    );

    cfgl_clkgen #(
        .CCLK_HALF   (CCLK_HALF),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_run (master_run),
        .slave_run  (slave_run),
        .ext_cclk   (ext_cclk),
        .cclk_out   (cclk_out),
        .beat       (beat)
    );

    cfgl_assembler #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (load_en),
        .beat       (beat),
        .byte_mode  (byte_mode),
        .ser_bit    (ser_din),
        .par_byte   (par_din),
        .word_valid (word_valid),
        .word_data  (mem_wdata)
    );

    // daisy-chain output: high until full, then forwards serial bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            dout_q <= 1'b1;
        else if (!pass_en)                     dout_q <= 1'b1;
        else if (beat && !byte_mode)           dout_q <= ser_din;
    end

    assign dout      = dout_q;
    assign mem_we    = word_valid;
    assign load_full = pass_en;
    assign mode_err  = fault;
    assign cclk_oe   = master_run;

endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
    parameter int WCNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [WCNT_W-1:0] mem_addr,
    input logic              load_full,
    input logic              dout,
    input logic              mode_err,
    input logic              cclk_oe,
    input logic              cclk_out
);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == WCNT_W'($past(mem_addr) + 1'b1)));

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6
    full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_full |-> !mem_we);

    // R6
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_full |=> load_full);

    // R7
    dout_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_full |-> dout);

    // R1
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!mem_we && !cclk_oe && !load_full));

    // R2
    clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cclk_oe |-> !cclk_out);

    // R8
    oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_oe |=> cclk_oe);

endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.WCNT_W(WCNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .load_full (load_full),
    .dout      (dout),
    .mode_err  (mode_err),
    .cclk_oe   (cclk_oe),
    .cclk_out  (cclk_out)
);

// File: tb/cfg_stream_loader_tb.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_pins = 3'b000;
    logic [7:0]  frame_total = 8'd0;
    logic        ext_cclk = 1'b0;
    logic        ser_din = 1'b0;
    logic [7:0]  par_din = 8'd0;
    logic        cclk_out, cclk_oe, mem_we, dout, load_full, mode_err;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;

    always #2 clk = ~clk;

    cfg_stream_loader #(
        .INIT_CYCLES (8),
        .CCLK_HALF   (HALF),
        .SYNC_STAGES (2),
        .WCNT_W      (8),
        .WORD_W      (32),
        .BYTE_W      (8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .frame_total(frame_total),
        .ext_cclk(ext_cclk), .ser_din(ser_din), .par_din(par_din),
        .cclk_out(cclk_out), .cclk_oe(cclk_oe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dout(dout), .load_full(load_full), .mode_err(mode_err)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int          wr_n = 0;
    logic [31:0] wr_data [0:63];
    logic [7:0]  wr_addr [0:63];
    logic [31:0] exp_w [0:7];
    logic        stream [0:255];

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (wr_n < 64) begin
                wr_data[wr_n] = mem_wdata;
                wr_addr[wr_n] = mem_addr;
            end
            wr_n = wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic msb_bit(input logic [31:0] w, input int j);
        return w[31-j];
    endfunction

    function automatic logic [7:0] lane(input logic [31:0] w, input int j);
        return w[31-8*j -: 8];
    endfunction

    task automatic start_case(input logic [2:0] m, input logic [7:0] tot, input int settle);
        rst_n = 1'b0;
        mode_pins = m;
        frame_total = tot;
        ext_cclk = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 0;
        rst_n = 1'b1;
        repeat (settle) @(negedge clk);
    endtask

    task automatic slave_beat(input logic b, input logic [7:0] by);
        ser_din = b;
        par_din = by;
        ext_cclk = 1'b1;
        repeat (4) @(negedge clk);
        ext_cclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_rise(output int gap);
        logic p;
        bit   seen;
        p = cclk_out;
        gap = 0;
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            gap++;
            if (cclk_out && !p) seen = 1'b1;
            p = cclk_out;
        end
    endtask

    task automatic check_words(input int n, input string tag);
        chk(wr_n == n, {tag, " write count"}, wr_n, n);
        for (int i = 0; i < n; i++) begin
            chk(wr_data[i] == exp_w[i], {tag, " word data"}, wr_data[i], exp_w[i]);
            chk(wr_addr[i] == 8'(i), "R5 word address", {24'd0, wr_addr[i]}, i);
        end
    endtask

    initial begin
        int  seed_v;
        int  gap;
        bit  hi_ok;
        seed_v = $urandom(32'h5eed_c0f1);

        // R9 reset state
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0, "R9 mem_we in reset", {31'd0, mem_we}, 0);
        chk(dout == 1'b1, "R9 dout in reset", {31'd0, dout}, 1);
        chk(mode_err == 1'b0, "R9 mode_err in reset", {31'd0, mode_err}, 0);
        chk(cclk_oe == 1'b0, "R9 cclk_oe in reset", {31'd0, cclk_oe}, 0);
        chk(load_full == 1'b0, "R9 load_full in reset", {31'd0, load_full}, 0);

        // Case A: master serial, 3 words then 16 forwarded bits (R2 R3 R5 R6 R7)
        exp_w[0] = 32'h8000_0001;
        for (int i = 1; i < 3; i++) exp_w[i] = $urandom;
        for (int i = 0; i < 96; i++) stream[i] = msb_bit(exp_w[i/32], i % 32);
        for (int i = 96; i < 112; i++) stream[i] = 1'($urandom);
        ser_din = stream[0];
        start_case(3'b000, 8'd3, 1);
        hi_ok = 1'b1;
        for (int k = 0; k < 112; k++) begin
            wait_rise(gap);
            if (k == 2) begin
                chk(gap == 2*HALF, "R2 generated clock period", gap, 2*HALF);
                chk(cclk_oe == 1'b1, "R2 cclk_oe in master", {31'd0, cclk_oe}, 1);
            end
            if (k >= 96) chk(dout == stream[k], "R7 master forward bit", {31'd0, dout}, {31'd0, stream[k]});
            else if (dout !== 1'b1) hi_ok = 1'b0;
            ser_din = (k < 111) ? stream[k+1] : 1'b0;
        end
        repeat (10) @(negedge clk);
        chk(hi_ok, "R7 dout high during master load", {31'd0, hi_ok}, 1);
        check_words(3, "R3 master");
        chk(load_full == 1'b1, "R6 full after total", {31'd0, load_full}, 1);

        // Case B: slave serial, mode pins and total changed mid-load (R3 R8 R2)
        for (int i = 0; i < 2; i++) exp_w[i] = $urandom;
        start_case(3'b111, 8'd2, 12);
        for (int j = 0; j < 32; j++) slave_beat(msb_bit(exp_w[0], j), 8'hFF);
        chk(dout == 1'b1, "R7 dout high mid slave load", {31'd0, dout}, 1);
        chk(load_full == 1'b0, "R6 not full after 1 of 2", {31'd0, load_full}, 0);
        mode_pins = 3'b011;
        frame_total = 8'd1;
        for (int j = 0; j < 32; j++) slave_beat(msb_bit(exp_w[1], j), 8'h00);
        check_words(2, "R8 slave serial pins ignored");
        chk(cclk_oe == 1'b0 && cclk_out == 1'b0, "R2 no clock in slave", {30'd0, cclk_oe, cclk_out}, 0);
        for (int j = 0; j < 8; j++) begin
            logic b;
            b = 1'($urandom);
            slave_beat(b, 8'h00);
            chk(dout == b, "R7 slave forward bit", {31'd0, dout}, {31'd0, b});
        end
        chk(wr_n == 2, "R6 no write in pass", wr_n, 2);

        // Case C: byte-wide parallel, 4 words then extra bytes (R4 R6 R7)
        exp_w[0] = 32'h1122_3344;
        for (int i = 1; i < 4; i++) exp_w[i] = $urandom;
        start_case(3'b110, 8'd4, 12);
        hi_ok = 1'b1;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                slave_beat(1'b0, lane(exp_w[i], j));
                if (dout !== 1'b1) hi_ok = 1'b0;
            end
        for (int j = 0; j < 6; j++) begin
            slave_beat(1'b0, 8'($urandom));
            if (dout !== 1'b1) hi_ok = 1'b0;
        end
        check_words(4, "R4 parallel");
        chk(hi_ok, "R7 dout high in parallel mode", {31'd0, hi_ok}, 1);
        chk(load_full == 1'b1, "R6 parallel full", {31'd0, load_full}, 1);

        // Case D: unrecognised mode (R1)
        start_case(3'b010, 8'd2, 12);
        chk(mode_err == 1'b1, "R1 mode_err on 010", {31'd0, mode_err}, 1);
        for (int j = 0; j < 40; j++) slave_beat(1'($urandom), 8'($urandom));
        chk(wr_n == 0, "R1 no write in fault", wr_n, 0);
        chk(cclk_oe == 1'b0 && cclk_out == 1'b0, "R1 no clock in fault", {30'd0, cclk_oe, cclk_out}, 0);
        chk(dout == 1'b1 && load_full == 1'b0, "R1 dout and full in fault", {30'd0, dout, load_full}, 2);

        // Case E: zero total, forwarding from the first bit (R6 R7)
        start_case(3'b111, 8'd0, 12);
        chk(load_full == 1'b1, "R6 zero total full", {31'd0, load_full}, 1);
        for (int j = 0; j < 10; j++) begin
            logic b;
            b = (j % 2 == 0) ? 1'b0 : 1'($urandom);
            slave_beat(b, 8'h00);
            chk(dout == b, "R7 zero total forward", {31'd0, dout}, {31'd0, b});
        end
        chk(wr_n == 0, "R6 zero total no write", wr_n, 0);

        // Case F: pins change during INIT, sampled at its end; partial word (R8 R6)
        exp_w[0] = $urandom;
        rst_n = 1'b0;
        mode_pins = 3'b010;
        frame_total = 8'd2;
        repeat (3) @(negedge clk);
        wr_n = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mode_pins = 3'b111;
        repeat (12) @(negedge clk);
        chk(mode_err == 1'b0, "R8 late init pins used", {31'd0, mode_err}, 0);
        for (int j = 0; j < 32; j++) slave_beat(msb_bit(exp_w[0], j), 8'h00);
        for (int j = 0; j < 20; j++) slave_beat(1'($urandom), 8'h00);
        check_words(1, "R8 init sampling");
        chk(load_full == 1'b0, "R6 partial word not full", {31'd0, load_full}, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule